// File: doc/BRIEF.md
# Single-Port Write-First RAM with Output Preset

A synchronous single-port memory with a registered data output. Each clock edge performs at most one operation on the one port. A write stores the input word and passes that same word to the output register on the same edge. A read loads the addressed word into the output register. A preset loads a fixed parameter value into the output register and does not touch the storage array. A port enable gates all three operations. When the enable is low, the array and the output register both keep their values.

The preset acts only on the output register. Because of this, a write and a preset on the same edge still update the array, while the output takes the preset value. A synchronous active-low reset returns the output register to its power-up value and blocks writes for as long as it is held. All other controls are active high.

Top module: `spram_wf_preset`

## Requirements
- R1: On a rising edge with rst_n=1, en=1 and we=1, the word on din is stored at location addr. A later read of that location returns it.
- R2: After an edge with rst_n=1, en=1, we=1 and sr=0, dout equals the din of that edge.
- R3: After an edge with rst_n=1, en=1 and sr=1, dout equals SR_VALUE (default 16'h0101), whatever addr and din were.
- R4: An edge with en=1, we=0 and sr=1 leaves every stored word unchanged.
- R5: After an edge with rst_n=1, en=1, we=0 and sr=0, dout equals the word stored at addr before that edge.
- R6: After an edge with rst_n=1 and en=0, dout is unchanged and no stored word changes, whatever we, sr, addr and din are.
- R7: On an edge with rst_n=1, en=1, we=1 and sr=1, din is stored at addr and dout becomes SR_VALUE.
- R8: After an edge with rst_n=0, dout equals INIT_VALUE (default 16'h0000), and no stored word changes on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| en | input | 1 | Port enable; gates write, read and preset |
| we | input | 1 | Write enable |
| sr | input | 1 | Synchronous preset of the output register |
| addr | input | ADDR_W (10) | Word address |
| din | input | DATA_W (16) | Write data |
| dout | output | DATA_W (16) | Registered read data |

## Verification
The bench aims at edges where controls overlap. Writing and presetting together must still store the word. A design that lets the preset block the write would later read back stale data. A preset on a read edge must not modify the array. The check for this reads the location back afterwards, so a design that wrote din during the preset would be caught. Edges with the enable low carry active we, sr and data to show that neither the array nor dout moves. A long random mix compared against a reference array catches an output that shows the old word on a write edge instead of the new one.

// File: rtl/spram_pkg.sv
// Shared types for the single-port write-first RAM.
// Assumes: consumers import the package; no state lives here.
package spram_pkg;

    // Source that the output register loads on the coming edge
    typedef enum logic [2:0] {
        OSEL_HOLD  = 3'd0,
        OSEL_WDATA = 3'd1,
        OSEL_RDATA = 3'd2,
        OSEL_PRESET = 3'd3
    } out_sel_e;

endpackage

// File: rtl/spram_ctrl.sv
// Port control decode: turns enable, write enable, preset and reset into
// an array write strobe and an output-register source select.
// Assumes: all inputs are synchronous to the array clock.
module spram_ctrl
    import spram_pkg::*;
(
    input  logic     rst_n,
    input  logic     en,
    input  logic     we,
    input  logic     sr,
    output logic     mem_wr,
    output out_sel_e out_sel
);

    // Write strobe: enabled write outside reset; preset does not block it
    always_comb begin
        mem_wr = rst_n & en & we;
    end

    // Output source: preset wins over write-first and read data
    always_comb begin
        if (!en)
            out_sel = OSEL_HOLD;
        else if (sr)
            out_sel = OSEL_PRESET;
        else if (we)
            out_sel = OSEL_WDATA;
        else
            out_sel = OSEL_RDATA;
    end

endmodule

// File: rtl/spram_array.sv
// Storage array: one synchronous write port and an asynchronous read view
// of the addressed word; the read view is registered downstream.
// Assumes: no reset of contents; rst_n is used by the checks only.
module spram_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write word on a strobed edge
    always_ff @(posedge clk) begin
        if (wr)
            mem[addr] <= wdata;
    end

    // Present the addressed word to the output register
    always_comb begin
        rdata = mem[addr];
    end

    // R1: the strobed location holds the written word after the edge
    assert_write_stores_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/spram_outreg.sv
// Output register: loads reset value, preset value, write-through data or
// read data, or holds, as selected by the port control.
// Assumes: out_sel is already gated by the port enable.
module spram_outreg
    import spram_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] SR_VALUE   = 'h0101,
    parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  out_sel_e          out_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] q
);

    // Register update per selected source, reset first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT_VALUE;
        end else begin
            case (out_sel)
                OSEL_WDATA:  q <= wdata;
                OSEL_RDATA:  q <= rdata;
                OSEL_PRESET: q <= SR_VALUE;
                default:     q <= q;
            endcase
        end
    end

    // R5: a read edge loads the word the array presented
    assert_read_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == OSEL_RDATA) |=> (q == $past(rdata)));

endmodule

// File: rtl/spram_wf_preset.sv
// Single-port synchronous RAM, write-first, with a synchronous preset of
// the registered output that never alters stored data.
// Assumes: one clock; rst_n synchronous active low; controls active high.
module spram_wf_preset
    import spram_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                ADDR_W     = 10,
    parameter logic [DATA_W-1:0] SR_VALUE   = 'h0101,
    parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic              sr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic              mem_wr;
    out_sel_e          out_sel;
    logic [DATA_W-1:0] rd_word;

    spram_ctrl u_ctrl (
        .rst_n   (rst_n),
        .en      (en),
        .we      (we),
        .sr      (sr),
        .mem_wr  (mem_wr),
        .out_sel (out_sel)
    );

    spram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mem_wr),
        .addr  (addr),
        .wdata (din),
        .rdata (rd_word)
    );

    spram_outreg #(.DATA_W(DATA_W), .SR_VALUE(SR_VALUE), .INIT_VALUE(INIT_VALUE)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_sel (out_sel),
        .wdata   (din),
        .rdata   (rd_word),
        .q       (dout)
    );

    // R2: write without preset shows the new word after the same edge
    assert_write_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we && !sr) |=> (dout == $past(din)));

    // R3 and R7: enabled preset loads the constant, write or not
    assert_preset_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sr) |=> (dout == SR_VALUE));

    // R6: disabled edge leaves the output untouched
    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(dout));

    // R7: simultaneous write and preset still strobes the array
    assert_preset_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we && sr) |-> mem_wr);

endmodule

// File: tb/tb_spram_wf_preset.sv
module tb_spram_wf_preset;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 10;
    localparam logic [DW-1:0] SRV  = 16'h0101;
    localparam logic [DW-1:0] INIT = 16'h0000;
    localparam int WIN = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, we = 1'b0, sr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;

    logic [DW-1:0] mref [WIN];
    logic [DW-1:0] oref;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spram_wf_preset #(.DATA_W(DW), .ADDR_W(AW), .SR_VALUE(SRV), .INIT_VALUE(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .we(we), .sr(sr),
        .addr(addr), .din(din), .dout(dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    // One edge: drive at negedge, apply model, sample 1 time unit after posedge
    task automatic cyc(input logic r, input logic e, input logic w, input logic s,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        rst_n = r; en = e; we = w; sr = s; addr = a; din = d;
        @(posedge clk);
        #1;
        if (!r) oref = INIT;
        else if (e) begin
            if (s)      oref = SRV;
            else if (w) oref = d;
            else        oref = mref[a];
            if (w) mref[a] = d;
        end
    endtask

    task automatic t_reset();
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 10'd3, 16'hDEAD);
        chk("R8 reset value", dout, INIT);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'd3, 16'h0);
        chk("R8 no write in reset", dout, mref[3]);
    endtask

    task automatic t_fill();
        for (int i = 0; i < WIN; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b0, AW'(i), DW'(16'h1000 + i * 16'h0111));
            chk("R2 write-first on fill", dout, DW'(16'h1000 + i * 16'h0111));
        end
    endtask

    task automatic t_readback();
        for (int i = WIN - 1; i >= 0; i--) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0, AW'(i), 16'h5A5A);
            chk("R1 R5 read back", dout, mref[i]);
        end
    endtask

    task automatic t_preset();
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 10'd7, 16'hBEEF);
        chk("R3 preset value", dout, SRV);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'd7, 16'h0);
        chk("R4 preset left memory", dout, mref[7]);
    endtask

    task automatic t_preset_write();
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 10'd9, 16'hC0DE);
        chk("R7 output preset on write", dout, SRV);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'd9, 16'h0);
        chk("R7 word stored on preset", dout, 16'hC0DE);
    endtask

    task automatic t_disable();
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'd4, 16'h0);
        chk("R5 read before disable", dout, mref[4]);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 10'd4, 16'hFFFF);
        chk("R6 hold on disabled write", dout, mref[4]);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0);
        chk("R6 hold on disabled preset", dout, mref[4]);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'd4, 16'h0);
        chk("R6 memory kept", dout, mref[4]);
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            logic e, w, s;
            e = ($urandom_range(0, 3) != 0);
            w = $urandom_range(0, 1);
            s = ($urandom_range(0, 5) == 0);
            cyc(1'b1, e, w, s, AW'($urandom_range(0, WIN - 1)), DW'($urandom));
            chk("R2 R3 R5 R6 random mix", dout, oref);
        end
    endtask

    initial begin
        oref = INIT;
        t_reset();
        t_fill();
        t_readback();
        t_preset();
        t_preset_write();
        t_disable();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: dout=%h expected=completion", dout);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule